// File: doc/BRIEF.md
# Phase-Sliced Shared Single-Port RAM

This block lets two 8-bit processors use one single-port RAM as if each owned it. The block runs at twice the processor cycle rate and splits every processor period into two slots. Processor A owns the first slot and processor B owns the second. The block drives a phase output `phi` that is high during A's slot. Processor A is clocked from `phi` and processor B from its inverse, so their memory cycles fall in opposite halves of the period.

In each slot the RAM takes its address, write data and write strobe only from the processor that owns the slot. The other processor's bus is cut off: its address, data and strobe are ignored, and its read data register holds steady. Each processor has its own read holding register. This register is loaded once per period and then presents the read word for a full period. Because the alternation is fixed, there is no arbiter and no wait state. The second slot could equally serve a non-processor agent, such as a display refresh engine.

The default memory is 1 K words. The address width can be raised, for example to 15 bits for a 32 KB window that both processors see.

Top module: `phase_shared_ram`

## Requirements
- R1: While `rst_n` is low and up to the first clock edge after its release, `phi` is 1 and both `a_rdata` and `b_rdata` are 0.
- R2: After reset the slots alternate A, B, A, B on successive clock cycles, starting with A. `phi` is 1 exactly in A slots.
- R3: In an A slot the RAM uses `a_addr`, `a_wdata` and `a_we`. A write from A is committed only at the end of an A slot.
- R4: In a B slot the RAM uses `b_addr`, `b_wdata` and `b_we`. A write from B is committed only at the end of a B slot.
- R5: The inputs of the processor that does not own the current slot have no effect. In particular, a write strobe raised outside its own slot never changes the memory.
- R6: The word addressed by A in an A slot appears on `a_rdata` from the start of the next A slot and is held for two clock cycles.
- R7: The word addressed by B in a B slot appears on `b_rdata` from the start of the next B slot and is held for two clock cycles.
- R8: A slot that both reads and writes one address returns the old content when `WRITE_THROUGH` is 0 (the default) and the new data when it is 1.
- R9: Both processors share one memory. Accesses take effect in slot order (A of a period, then B of the same period), so a word written by one side is read back by the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the processor cycle rate |
| rst_n | input | 1 | Active-low synchronous reset |
| phi | output | 1 | Slot phase: 1 in A slots, 0 in B slots |
| a_addr | input | ADDR_W | Processor A address |
| a_wdata | input | DATA_W | Processor A write data |
| a_we | input | 1 | Processor A write strobe |
| a_rdata | output | DATA_W | Processor A held read data |
| b_addr | input | ADDR_W | Processor B address |
| b_wdata | input | DATA_W | Processor B write data |
| b_we | input | 1 | Processor B write strobe |
| b_rdata | output | DATA_W | Processor B held read data |

## Verification
The hardest case to reach is a stray access from the idle side. A processor raises its strobe with a fresh address while the other side owns the RAM. A real processor is never caught in that state, because its own clock is idle then. The bench therefore overwrites each side's bus with random writes at the start of the other side's slot in every period, and also places targeted stray writes on known words. Every later read is compared against a reference memory, which would show a leaked write. Address ranges are kept narrow so that both sides often hit the same word within one period.

// File: rtl/shram_pkg.sv
`timescale 1ns/1ps
package shram_pkg;
   typedef enum logic [0:0] {
      SLOT_A = 1'b0,
      SLOT_B = 1'b1
   } slot_e;
   localparam int NUM_SIDES = 2;
endpackage

// File: rtl/shram_slot_seq.sv
`timescale 1ns/1ps
module shram_slot_seq
   import shram_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   output slot_e slot
);
   always_ff @(posedge clk) begin
      if (!rst_n) slot <= SLOT_A;
      else        slot <= (slot == SLOT_A) ? SLOT_B : SLOT_A;
   end

   // R2: strict alternation of owners
   a_r2_a_then_b: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == SLOT_A) |=> (slot == SLOT_B));
   a_r2_b_then_a: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == SLOT_B) |=> (slot == SLOT_A));
endmodule

// File: rtl/shram_mux.sv
`timescale 1ns/1ps
module shram_mux
   import shram_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
)(
   input  slot_e                                  slot,
   input  logic [NUM_SIDES-1:0][ADDR_W-1:0]       addr_i,
   input  logic [NUM_SIDES-1:0][DATA_W-1:0]       wdata_i,
   input  logic [NUM_SIDES-1:0]                   we_i,
   output logic [ADDR_W-1:0]                      addr_o,
   output logic [DATA_W-1:0]                      wdata_o,
   output logic                                   we_o
);
   logic sel;
   always_comb begin
      sel     = slot;
      addr_o  = addr_i[sel];
      wdata_o = wdata_i[sel];
      we_o    = we_i[sel];
   end
endmodule

// File: rtl/shram_spram.sv
`timescale 1ns/1ps
module shram_spram #(
   parameter int ADDR_W        = 10,
   parameter int DATA_W        = 8,
   parameter bit WRITE_THROUGH = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              we,
   output logic [DATA_W-1:0] q
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] rd_next;

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   generate
      if (WRITE_THROUGH) begin : g_wt
         always_comb rd_next = we ? wdata : mem[addr];
      end else begin : g_rf
         always_comb rd_next = mem[addr];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= rd_next;
   end
endmodule

// File: rtl/shram_hold.sv
`timescale 1ns/1ps
module shram_hold
   import shram_pkg::*;
#(
   parameter int    DATA_W = 8,
   parameter slot_e OWNER  = SLOT_A
)(
   input  logic              clk,
   input  logic              rst_n,
   input  slot_e             slot,
   input  logic [DATA_W-1:0] ram_q,
   output logic [DATA_W-1:0] held
);
   // ram_q carries the owner's word during the slot after the owner's slot
   always_ff @(posedge clk) begin
      if (!rst_n)              held <= '0;
      else if (slot != OWNER)  held <= ram_q;
   end

   // R6 (owner A) / R7 (owner B): value only moves on the capture edge
   a_r6_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (slot != OWNER) |-> $stable(held));
endmodule

// File: rtl/phase_shared_ram.sv
`timescale 1ns/1ps
module phase_shared_ram
   import shram_pkg::*;
#(
   parameter int ADDR_W        = 10,
   parameter int DATA_W        = 8,
   parameter bit WRITE_THROUGH = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   output logic              phi,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   input  logic              a_we,
   output logic [DATA_W-1:0] a_rdata,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   input  logic              b_we,
   output logic [DATA_W-1:0] b_rdata
);
   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
         initial $error("phase_shared_ram: ADDR_W must be 1..16");
      end
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_data
         initial $error("phase_shared_ram: DATA_W must be 1..64");
      end
   endgenerate

   slot_e                                slot;
   logic [NUM_SIDES-1:0][ADDR_W-1:0]     addr_v;
   logic [NUM_SIDES-1:0][DATA_W-1:0]     wdata_v;
   logic [NUM_SIDES-1:0]                 we_v;
   logic [NUM_SIDES-1:0][DATA_W-1:0]     held_v;
   logic [ADDR_W-1:0]                    ram_addr;
   logic [DATA_W-1:0]                    ram_wdata;
   logic                                 ram_we;
   logic [DATA_W-1:0]                    ram_q;

   assign addr_v  = {b_addr,  a_addr};
   assign wdata_v = {b_wdata, a_wdata};
   assign we_v    = {b_we,    a_we};

   shram_slot_seq u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .slot  (slot)
   );

   assign phi = (slot == SLOT_A);

   shram_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
      .slot    (slot),
      .addr_i  (addr_v),
      .wdata_i (wdata_v),
      .we_i    (we_v),
      .addr_o  (ram_addr),
      .wdata_o (ram_wdata),
      .we_o    (ram_we)
   );

   shram_spram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WRITE_THROUGH(WRITE_THROUGH)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (ram_addr),
      .wdata (ram_wdata),
      .we    (ram_we),
      .q     (ram_q)
   );

   for (genvar i = 0; i < NUM_SIDES; i++) begin : g_hold
      shram_hold #(.DATA_W(DATA_W), .OWNER(i == 0 ? SLOT_A : SLOT_B)) u_hold (
         .clk   (clk),
         .rst_n (rst_n),
         .slot  (slot),
         .ram_q (ram_q),
         .held  (held_v[i])
      );
   end

   assign a_rdata = held_v[0];
   assign b_rdata = held_v[1];

   // R3: a RAM write during phi high must come from A's strobe
   a_r3_we_from_a: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && phi) |-> a_we);
   // R4: a RAM write during phi low must come from B's strobe
   a_r4_we_from_b: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && !phi) |-> b_we);
   // R5: an idle side's strobe alone never reaches the RAM
   a_r5_idle_a_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (!phi && a_we && !b_we) |-> !ram_we);
   a_r5_idle_b_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (phi && b_we && !a_we) |-> !ram_we);
endmodule

// File: tb/sim_phase_shared_ram.sv
`timescale 1ns/1ps
module sim_phase_shared_ram;
   localparam int AW    = 10;
   localparam int DW    = 8;
   localparam bit WT    = 1'b0;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          phi;
   logic [AW-1:0] a_addr = '0, b_addr = '0;
   logic [DW-1:0] a_wdata = '0, b_wdata = '0;
   logic          a_we = 1'b0, b_we = 1'b0;
   logic [DW-1:0] a_rdata, b_rdata;

   always #4 clk = ~clk;

   phase_shared_ram #(.ADDR_W(AW), .DATA_W(DW), .WRITE_THROUGH(WT)) u0 (
      .clk(clk), .rst_n(rst_n), .phi(phi),
      .a_addr(a_addr), .a_wdata(a_wdata), .a_we(a_we), .a_rdata(a_rdata),
      .b_addr(b_addr), .b_wdata(b_wdata), .b_we(b_we), .b_rdata(b_rdata)
   );

   typedef struct {
      logic [DW-1:0] val;
      string         tag;
   } exp_t;

   exp_t          qa[$];
   exp_t          qb[$];
   logic [DW-1:0] ref_mem [DEPTH];
   int            last_w  [DEPTH];
   int            checks = 0;
   int            errors = 0;

   task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // reference model: side 1 = A, 2 = B
   task automatic ref_op(int side, logic [AW-1:0] ad, logic we, logic [DW-1:0] wd,
                         string force_tag, output exp_t e);
      string base;
      e.val = (we && WT) ? wd : ref_mem[ad];
      if (we)                                          base = "R8";
      else if (last_w[ad] != 0 && last_w[ad] != side)  base = "R9";
      else                                             base = (side == 1) ? "R3" : "R4";
      if (force_tag != "") base = force_tag;
      e.tag = $sformatf("%s %s", base, (side == 1) ? "R6" : "R7");
      if (we) begin
         ref_mem[ad] = wd;
         last_w[ad]  = side;
      end
   endtask

   // one processor period; entered at the negedge inside an A slot
   task automatic period(logic [AW-1:0] aa, logic awe, logic [DW-1:0] awd,
                         logic [AW-1:0] ba, logic bwe, logic [DW-1:0] bwd,
                         string ta = "", string tb = "",
                         int ja = -1, int jb = -1);
      exp_t e;
      check("R2 phi in A slot", {7'd0, phi}, 8'd1);
      if (qa.size() > 0) begin
         e = qa.pop_front();
         check(e.tag, a_rdata, e.val);
      end
      a_addr = aa; a_we = awe; a_wdata = awd;
      // stray B bus while A owns the RAM (R5)
      b_we    = 1'b1;
      b_addr  = (jb >= 0) ? AW'(jb) : AW'($urandom);
      b_wdata = (jb >= 0) ? 8'hDD : DW'($urandom);
      ref_op(1, aa, awe, awd, ta, e);
      qa.push_back(e);
      @(negedge clk);
      check("R2 phi in B slot", {7'd0, phi}, 8'd0);
      if (qb.size() > 0) begin
         e = qb.pop_front();
         check(e.tag, b_rdata, e.val);
      end
      b_addr = ba; b_we = bwe; b_wdata = bwd;
      // stray A bus while B owns the RAM (R5)
      a_we    = 1'b1;
      a_addr  = (ja >= 0) ? AW'(ja) : AW'($urandom);
      a_wdata = (ja >= 0) ? 8'hEE : DW'($urandom);
      ref_op(2, ba, bwe, bwd, tb, e);
      qb.push_back(e);
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #1500000;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         ref_mem[i] = '0;
         last_w[i]  = 0;
      end
      repeat (3) @(negedge clk);
      check("R1 phi in reset", {7'd0, phi}, 8'd1);
      check("R1 a_rdata in reset", a_rdata, 8'd0);
      check("R1 b_rdata in reset", b_rdata, 8'd0);
      rst_n = 1'b1;
      check("R1 a_rdata after release", a_rdata, 8'd0);
      check("R1 b_rdata after release", b_rdata, 8'd0);

      // fill: A writes even words, B writes odd words
      for (int k = 0; k < DEPTH / 2; k++) begin
         period(AW'(2 * k), 1'b1, DW'(k * 7 + 3), AW'(2 * k + 1), 1'b1, DW'(k * 5 + 1));
      end
      for (int k = 0; k < DEPTH; k++) last_w[k] = 0;

      // R9: A writes, B reads the same word in the same period
      period(AW'(100), 1'b1, 8'h5A, AW'(100), 1'b0, 8'h00);
      // R9: B writes, A reads it in the next period
      period(AW'(200), 1'b0, 8'h00, AW'(201), 1'b1, 8'hA5);
      period(AW'(201), 1'b0, 8'h00, AW'(100), 1'b0, 8'h00);
      // R8: read-during-write on both sides
      period(AW'(300), 1'b1, 8'h33, AW'(301), 1'b1, 8'h44);
      period(AW'(300), 1'b0, 8'h00, AW'(301), 1'b0, 8'h00);

      // R5: targeted stray writes on known words 40 and 41
      period(AW'(40), 1'b1, 8'h11, AW'(41), 1'b1, 8'h22);
      period(AW'(7), 1'b0, 8'h00, AW'(9), 1'b0, 8'h00, "", "", 41, 40);
      period(AW'(41), 1'b0, 8'h00, AW'(40), 1'b0, 8'h00, "R5", "R5", 41, 40);
      period(AW'(40), 1'b0, 8'h00, AW'(41), 1'b0, 8'h00, "R5", "R5");

      // random concurrent traffic on a narrow window to force collisions
      for (int k = 0; k < 3000; k++) begin
         logic [AW-1:0] aa, ba;
         aa = AW'(512 + ($urandom % 16));
         ba = ($urandom % 4 == 0) ? aa : AW'(512 + ($urandom % 16));
         period(aa, 1'($urandom), DW'($urandom), ba, 1'($urandom), DW'($urandom));
      end
      // drain the last pending results
      period(AW'(0), 1'b0, 8'h00, AW'(1), 1'b0, 8'h00);
      finish_run();
   end
endmodule